// File: doc/BRIEF.md
# DMA Transfer Completion Signaling

This block converts transfer-request completions of one DMA channel into chaining events and interrupt-pending flags. The channel's options word holds four independent enables and a 6-bit completion code. When a completion strobe arrives, the block checks whether the completed request was the last one of its parameter set. It then sets the bit selected by the completion code in the chained-event register, in the interrupt-pending register, in both or in neither.

An interrupt-enable register masks the pending flags. A single registered CPU interrupt line is raised while any pending flag is also enabled. Software uses a small command port to set or clear enable bits and to clear pending and chained-event bits by writing ones.

The options word also carries a 4-bit privilege ID. The block loads it with the writing master's privilege value whenever any word of the parameter set is written.

Top module: `xfer_done_signal`

## Requirements
- R1: After a synchronous reset, the options word, the chained-event register, the interrupt-pending register, the interrupt-enable register and `cpu_irq` are all 0.
- R2: A write to the options word stores the data bits 23:20, 17:12, 11:8 and 3:0. Bits 31:28, 19, 18 and 7:4 read back as 0 whatever was written. Bits 27:24 take `master_priv`, not the data. The new value appears on `opt_rdata` one cycle after the write.
- R3: A `pset_touch` strobe without an options write loads `master_priv` into bits 27:24 and leaves every other options bit unchanged.
- R4: A completion with `cmp_final`=0 while options bit 23 is 1 sets the chained-event bit at the index in options bits 17:12.
- R5: A completion with `cmp_final`=1 while options bit 22 is 1 sets the chained-event bit at the index in options bits 17:12.
- R6: A completion with `cmp_final`=0 while options bit 21 is 1 sets the interrupt-pending bit at the index in options bits 17:12.
- R7: A completion with `cmp_final`=1 while options bit 20 is 1 sets the interrupt-pending bit at the index in options bits 17:12.
- R8: A final completion never acts through bits 23 or 21, and a non-final completion never acts through bits 22 or 20. A completion whose matching enable is 0 sets nothing in that register.
- R9: `reg_op`=2 (pending clear) and `reg_op`=3 (chain clear) clear every bit where `reg_wdata` is 1. When a completion sets a bit in the same cycle that bit is cleared, the bit ends up set.
- R10: `reg_op`=0 sets, and `reg_op`=1 clears, every interrupt-enable bit where `reg_wdata` is 1. Other enable bits keep their value.
- R11: `cpu_irq` equals the OR over all positions of (pending AND enabled), taken from the register state one cycle earlier.
- R12: While `cmp_valid` is 0, the chained-event and interrupt-pending registers gain no set bits, whatever the options word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_wr | input | 1 | Write strobe for the options word |
| opt_wdata | input | 32 | Options word write data |
| pset_touch | input | 1 | Another word of the parameter set is being written |
| master_priv | input | 4 | Privilege value of the master doing the write |
| opt_rdata | output | 32 | Current options word |
| cmp_valid | input | 1 | Transfer-request completion strobe |
| cmp_final | input | 1 | Completed request was the final one of its set |
| reg_wr | input | 1 | Command port strobe |
| reg_op | input | 2 | 0 enable set, 1 enable clear, 2 pending clear, 3 chain clear |
| reg_wdata | input | 64 | Bit mask for the command |
| chain_evt | output | 64 | Chained-event register |
| int_pend | output | 64 | Interrupt-pending register |
| int_en | output | 64 | Interrupt-enable register |
| cpu_irq | output | 1 | Registered CPU interrupt |

## Verification
The clear-path assertion assumes that no completion is presented in the same cycle as a pending clear. The bench keeps collisions out of every scenario except the one that tests R9 directly, and that scenario is checked at the ports. The completion-path assertions take the completion code from `opt_rdata`, so they rely on the options word being stable while a completion is in flight. The stimulus never writes the options word in the same cycle as a completion. Completion codes are drawn at random over all 64 positions, and the four enables are swept through all sixteen combinations.

// File: rtl/xds_pkg.sv
package xds_pkg;
  localparam int OPT_W        = 32;
  localparam int CODE_LSB     = 12;
  localparam int PRIV_LSB     = 24;
  localparam int PRIV_W       = 4;
  localparam int BIT_MID_CHN  = 23;
  localparam int BIT_FIN_CHN  = 22;
  localparam int BIT_MID_INT  = 21;
  localparam int BIT_FIN_INT  = 20;
  // storable data bits: 23:20, 17:12, 11:8, 3:0
  localparam logic [OPT_W-1:0] OPT_WMASK = 32'h00F3_FF0F;

  typedef enum logic [1:0] {
    OP_EN_SET    = 2'd0,
    OP_EN_CLR    = 2'd1,
    OP_PEND_CLR  = 2'd2,
    OP_CHAIN_CLR = 2'd3
  } reg_op_e;
endpackage

// File: rtl/xds_opt_reg.sv
module xds_opt_reg
  import xds_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [OPT_W-1:0]  wdata,
  input  logic              touch,
  input  logic [PRIV_W-1:0] priv,
  output logic [OPT_W-1:0]  opt_q
);
  logic [OPT_W-1:0] priv_field;

  always_comb begin
    priv_field = '0;
    priv_field[PRIV_LSB +: PRIV_W] = priv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q <= '0;
    end else if (wr) begin
      opt_q <= (wdata & OPT_WMASK) | priv_field;
    end else if (touch) begin
      opt_q[PRIV_LSB +: PRIV_W] <= priv;
    end
  end
endmodule

// File: rtl/xds_evt_decode.sv
module xds_evt_decode #(
  parameter int N_POS  = 64,
  parameter int CODE_W = $clog2(N_POS)
) (
  input  logic              cmp_valid,
  input  logic              cmp_final,
  input  logic [CODE_W-1:0] code,
  input  logic              mid_chn_en,
  input  logic              fin_chn_en,
  input  logic              mid_int_en,
  input  logic              fin_int_en,
  output logic [N_POS-1:0]  chain_set,
  output logic [N_POS-1:0]  pend_set
);
  logic chain_fire;
  logic pend_fire;

  // final and intermediate completions use disjoint enables
  always_comb begin
    chain_fire = cmp_valid && (cmp_final ? fin_chn_en : mid_chn_en);
    pend_fire  = cmp_valid && (cmp_final ? fin_int_en : mid_int_en);
  end

  for (genvar i = 0; i < N_POS; i++) begin : g_pos
    logic hit;
    assign hit          = (code == CODE_W'(i));
    assign chain_set[i] = chain_fire && hit;
    assign pend_set[i]  = pend_fire && hit;
  end
endmodule

// File: rtl/xds_flag_bank.sv
module xds_flag_bank #(
  parameter int N_POS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_POS-1:0] set_mask,
  input  logic [N_POS-1:0] clr_mask,
  output logic [N_POS-1:0] q
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/xds_irq_reduce.sv
module xds_irq_reduce #(
  parameter int N_POS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_POS-1:0] pend,
  input  logic [N_POS-1:0] en,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & en);
  end
endmodule

// File: rtl/xfer_done_signal.sv
module xfer_done_signal
  import xds_pkg::*;
#(
  parameter int N_POS  = 64,
  parameter int CODE_W = $clog2(N_POS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opt_wr,
  input  logic [OPT_W-1:0]  opt_wdata,
  input  logic              pset_touch,
  input  logic [PRIV_W-1:0] master_priv,
  output logic [OPT_W-1:0]  opt_rdata,
  input  logic              cmp_valid,
  input  logic              cmp_final,
  input  logic              reg_wr,
  input  logic [1:0]        reg_op,
  input  logic [N_POS-1:0]  reg_wdata,
  output logic [N_POS-1:0]  chain_evt,
  output logic [N_POS-1:0]  int_pend,
  output logic [N_POS-1:0]  int_en,
  output logic              cpu_irq
);
  reg_op_e          op;
  logic [N_POS-1:0] chain_set, pend_set;
  logic [N_POS-1:0] chain_clr, pend_clr, en_set, en_clr;

  xds_opt_reg u_opt (
    .clk   (clk),
    .rst   (rst),
    .wr    (opt_wr),
    .wdata (opt_wdata),
    .touch (pset_touch),
    .priv  (master_priv),
    .opt_q (opt_rdata)
  );

  xds_evt_decode #(.N_POS(N_POS), .CODE_W(CODE_W)) u_dec (
    .cmp_valid  (cmp_valid),
    .cmp_final  (cmp_final),
    .code       (opt_rdata[CODE_LSB +: CODE_W]),
    .mid_chn_en (opt_rdata[BIT_MID_CHN]),
    .fin_chn_en (opt_rdata[BIT_FIN_CHN]),
    .mid_int_en (opt_rdata[BIT_MID_INT]),
    .fin_int_en (opt_rdata[BIT_FIN_INT]),
    .chain_set  (chain_set),
    .pend_set   (pend_set)
  );

  always_comb begin
    op        = reg_op_e'(reg_op);
    en_set    = (reg_wr && op == OP_EN_SET)    ? reg_wdata : '0;
    en_clr    = (reg_wr && op == OP_EN_CLR)    ? reg_wdata : '0;
    pend_clr  = (reg_wr && op == OP_PEND_CLR)  ? reg_wdata : '0;
    chain_clr = (reg_wr && op == OP_CHAIN_CLR) ? reg_wdata : '0;
  end

  xds_flag_bank #(.N_POS(N_POS)) u_chain (
    .clk(clk), .rst(rst), .set_mask(chain_set), .clr_mask(chain_clr), .q(chain_evt)
  );

  xds_flag_bank #(.N_POS(N_POS)) u_pend (
    .clk(clk), .rst(rst), .set_mask(pend_set), .clr_mask(pend_clr), .q(int_pend)
  );

  xds_flag_bank #(.N_POS(N_POS)) u_en (
    .clk(clk), .rst(rst), .set_mask(en_set), .clr_mask(en_clr), .q(int_en)
  );

  xds_irq_reduce #(.N_POS(N_POS)) u_irq (
    .clk(clk), .rst(rst), .pend(int_pend), .en(int_en), .irq(cpu_irq)
  );
endmodule

// File: rtl/xfer_done_signal_checker.sv
module xfer_done_signal_checker #(
  parameter int N_POS  = 64,
  parameter int CODE_W = $clog2(N_POS)
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      opt_rdata,
  input logic             cmp_valid,
  input logic             cmp_final,
  input logic             reg_wr,
  input logic [1:0]       reg_op,
  input logic [N_POS-1:0] reg_wdata,
  input logic [N_POS-1:0] chain_evt,
  input logic [N_POS-1:0] int_pend,
  input logic [N_POS-1:0] int_en,
  input logic             cpu_irq
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chain_evt == '0 && int_pend == '0 && int_en == '0 && !cpu_irq && opt_rdata == '0));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    opt_rdata[31:28] == 4'h0 && opt_rdata[19:18] == 2'b00 && opt_rdata[7:4] == 4'h0);

  assert_mid_chain_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_final && opt_rdata[23]) |=> chain_evt[$past(opt_rdata[12 +: CODE_W])]);

  assert_fin_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_final && opt_rdata[20]) |=> int_pend[$past(opt_rdata[12 +: CODE_W])]);

  assert_fin_no_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_final && !opt_rdata[22]) |=> ((chain_evt & ~$past(chain_evt)) == '0));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_op == 2'd2 && !cmp_valid) |=> ((int_pend & $past(reg_wdata)) == '0));

  assert_irq_lag_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == |($past(int_pend & int_en))));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> ((int_pend & ~$past(int_pend)) == '0 && (chain_evt & ~$past(chain_evt)) == '0));
endmodule

bind xfer_done_signal xfer_done_signal_checker #(.N_POS(N_POS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .opt_rdata(opt_rdata), .cmp_valid(cmp_valid), .cmp_final(cmp_final),
  .reg_wr(reg_wr), .reg_op(reg_op), .reg_wdata(reg_wdata), .chain_evt(chain_evt),
  .int_pend(int_pend), .int_en(int_en), .cpu_irq(cpu_irq)
);

// File: tb/xfer_done_signal_bench.sv
`timescale 1ns/1ps
module xfer_done_signal_bench;
  localparam logic [31:0] WMASK = 32'h00F3_FF0F;
  localparam logic [63:0] ONES  = {64{1'b1}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opt_wr = 1'b0, pset_touch = 1'b0, cmp_valid = 1'b0, cmp_final = 1'b0, reg_wr = 1'b0;
  logic [31:0] opt_wdata = '0;
  logic [3:0]  master_priv = '0;
  logic [1:0]  reg_op = '0;
  logic [63:0] reg_wdata = '0;
  logic [31:0] opt_rdata;
  logic [63:0] chain_evt, int_pend, int_en;
  logic        cpu_irq;

  logic [31:0] m_opt;
  logic [63:0] m_chain, m_pend, m_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xfer_done_signal u_xfer_done_signal (
    .clk(clk), .rst(rst), .opt_wr(opt_wr), .opt_wdata(opt_wdata), .pset_touch(pset_touch),
    .master_priv(master_priv), .opt_rdata(opt_rdata), .cmp_valid(cmp_valid),
    .cmp_final(cmp_final), .reg_wr(reg_wr), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .chain_evt(chain_evt), .int_pend(int_pend), .int_en(int_en), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic program_opt(input logic [31:0] d, input logic [3:0] p);
    @(negedge clk); opt_wr = 1; opt_wdata = d; master_priv = p;
    @(negedge clk); opt_wr = 0;
    m_opt = (d & WMASK) | ({28'h0, p} << 24);
  endtask

  task automatic complete(input logic fin);
    int c;
    c = int'(m_opt[17:12]);
    @(negedge clk); cmp_valid = 1; cmp_final = fin;
    @(negedge clk); cmp_valid = 0;
    if (fin) begin
      if (m_opt[22]) m_chain[c] = 1'b1;
      if (m_opt[20]) m_pend[c]  = 1'b1;
    end else begin
      if (m_opt[23]) m_chain[c] = 1'b1;
      if (m_opt[21]) m_pend[c]  = 1'b1;
    end
  endtask

  task automatic reg_access(input logic [1:0] op, input logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_op = op; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    case (op)
      2'd0: m_en    = m_en | d;
      2'd1: m_en    = m_en & ~d;
      2'd2: m_pend  = m_pend & ~d;
      default: m_chain = m_chain & ~d;
    endcase
  endtask

  task automatic t_reset();
    chk("R1", "opt", {32'h0, opt_rdata}, 64'h0);
    chk("R1", "chain", chain_evt, 64'h0);
    chk("R1", "pend", int_pend, 64'h0);
    chk("R1", "en", int_en, 64'h0);
    chk("R1", "irq", {63'h0, cpu_irq}, 64'h0);
  endtask

  task automatic t_opt_write();
    program_opt(32'hFFFF_FFFF, 4'hA);
    chk("R2", "all-ones write", {32'h0, opt_rdata}, {32'h0, 32'h0AF3_FF0F});
    program_opt(32'h5A5A_5A5A, 4'h3);
    chk("R2", "pattern write", {32'h0, opt_rdata}, {32'h0, m_opt});
  endtask

  task automatic t_priv_touch();
    @(negedge clk); pset_touch = 1; master_priv = 4'h6;
    @(negedge clk); pset_touch = 0;
    m_opt[27:24] = 4'h6;
    chk("R3", "touch", {32'h0, opt_rdata}, {32'h0, m_opt});
  endtask

  task automatic t_enable_combos();
    for (int e = 0; e < 16; e++) begin
      logic [5:0] code;
      code = 6'($urandom % 64);
      reg_access(2'd2, ONES);
      reg_access(2'd3, ONES);
      program_opt((32'(e) << 20) | (32'(code) << 12) | 32'($urandom & 32'hF0F), 4'h1);
      complete(1'b0);
      chk("R4,R8", "chain after mid", chain_evt, m_chain);
      chk("R6,R8", "pend after mid", int_pend, m_pend);
      reg_access(2'd2, ONES);
      reg_access(2'd3, ONES);
      complete(1'b1);
      chk("R5,R8", "chain after fin", chain_evt, m_chain);
      chk("R7,R8", "pend after fin", int_pend, m_pend);
    end
  endtask

  task automatic t_idle();
    reg_access(2'd2, ONES);
    reg_access(2'd3, ONES);
    program_opt(32'h00F2_A000, 4'h2);
    repeat (5) @(negedge clk);
    chk("R12", "chain idle", chain_evt, 64'h0);
    chk("R12", "pend idle", int_pend, 64'h0);
  endtask

  task automatic t_w1c();
    program_opt(32'h0020_5000, 4'h0); // mid interrupt, code 5
    complete(1'b0);
    program_opt(32'h0020_9000, 4'h0); // mid interrupt, code 9
    complete(1'b0);
    chk("R6", "two pend bits", int_pend, m_pend);
    // collision: clear 5 and 9 while code 9 completes again
    @(negedge clk); cmp_valid = 1; cmp_final = 0; reg_wr = 1; reg_op = 2'd2;
    reg_wdata = (64'h1 << 5) | (64'h1 << 9);
    @(negedge clk); cmp_valid = 0; reg_wr = 0;
    chk("R9", "set wins", int_pend, 64'h1 << 9);
    m_pend = 64'h1 << 9;
    program_opt(32'h0080_3000, 4'h0); // mid chain, code 3
    complete(1'b0);
    reg_access(2'd3, 64'h1 << 3);
    chk("R9", "chain clear", chain_evt, m_chain);
  endtask

  task automatic t_irq();
    @(negedge clk);
    chk("R11", "masked", {63'h0, cpu_irq}, 64'h0);
    reg_access(2'd0, (64'h1 << 9) | (64'h1 << 40));
    chk("R10", "en set", int_en, m_en);
    chk("R11", "irq lags", {63'h0, cpu_irq}, 64'h0);
    @(negedge clk);
    chk("R11", "irq high", {63'h0, cpu_irq}, 64'h1);
    reg_access(2'd1, 64'h1 << 9);
    chk("R10", "en clear", int_en, m_en);
    @(negedge clk);
    chk("R11", "irq after mask", {63'h0, cpu_irq}, {63'h0, |(m_pend & m_en)});
    reg_access(2'd0, 64'h1 << 9);
    reg_access(2'd2, 64'h1 << 9);
    @(negedge clk);
    chk("R11", "irq after clear", {63'h0, cpu_irq}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    m_opt = '0; m_chain = '0; m_pend = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_opt_write();
    t_priv_touch();
    t_enable_combos();
    t_idle();
    t_w1c();
    t_irq();
    summary();
  end
endmodule